// File: doc/BRIEF.md
# SHA-256 Message Schedule Update Unit

This block produces four new SHA-256 message schedule words per operation. It takes 128-bit vectors of four 32-bit lanes and runs one of two operations, picked by a single select bit. The partial operation adds the small-sigma-0 term of the next-older word to each word of the destination vector. The completing operation adds the small-sigma-1 term of a recent word and the lag-7 word. In the completing operation the two upper result lanes are built from the two lower result lanes of the same operation, so one operation holds a chained dependency.

A caller presents the three operand vectors with a valid strobe. One clock later the result appears on a registered output with its own valid flag. The result stays unchanged until the next valid input is accepted.

Top module: `msg_sched_unit`

## Requirements
- R1: After reset, `outValid` is 0 and `result` is all zeros.
- R2: `outValid` is 1 in the cycle after a cycle with `inValid` = 1, and 0 in the cycle after a cycle with `inValid` = 0.
- R3: With `opSel` = 0, result lane i (i = 0, 1, 2) equals s0(dst lane i+1) + dst lane i. Here s0(x) = rotr(x,7) ^ rotr(x,18) ^ (x >> 3).
- R4: With `opSel` = 0, result lane 3 equals s0(srcA lane 0) + dst lane 3.
- R5: With `opSel` = 1, r0 = s1(srcB lane 2) + dst lane 0 + srcA lane 1, and r1 = s1(srcB lane 3) + dst lane 1 + srcA lane 2. Here s1(x) = rotr(x,17) ^ rotr(x,19) ^ (x >> 10).
- R6: With `opSel` = 1, r2 = s1(r0) + dst lane 2 + srcA lane 3, and r3 = s1(r1) + dst lane 3 + srcB lane 0.
- R7: While `inValid` is 0, `result` keeps the value of the last accepted operation.
- R8: With `opSel` = 0, `srcB` and srcA lanes 1 to 3 have no effect on the result.
- R9: Every addition wraps modulo 2^32. Lane k occupies bits [32k+31:32k], so lane 0 is bits [31:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands valid, start an operation |
| opSel | input | 1 | 0 = partial (sigma-0) update, 1 = completing (sigma-1) update |
| dstVec | input | 128 | Destination operand, four 32-bit lanes |
| srcA | input | 128 | First source operand |
| srcB | input | 128 | Second source operand |
| outValid | output | 1 | Result produced by the previous cycle's operation |
| result | output | 128 | Registered result vector |

## Verification
Two things can happen in the same cycle. A new operation can be accepted while the previous result is still being presented, and that new operation can use the other select value. The bench provokes this with back-to-back valid inputs that switch between the partial and completing operations on consecutive cycles. It also inserts idle gaps between runs. Each cycle's output is judged against an arithmetic model of the operation accepted one edge earlier, and the hold value is checked in every idle cycle that follows.

// File: rtl/msgsched_pkg.sv
package msgsched_pkg;
  localparam int LANE_W = 32;
  localparam int LANES  = 4;
  localparam int VEC_W  = LANE_W * LANES;

  typedef struct packed {
    logic load;       // capture a new result this cycle
    logic finishOp;   // 1: completing update, 0: partial update
  } schedStrobes_t;

  function automatic logic [LANE_W-1:0] smallSig0(input logic [LANE_W-1:0] x);
    return {x[6:0], x[31:7]} ^ {x[17:0], x[31:18]} ^ (x >> 3);
  endfunction

  function automatic logic [LANE_W-1:0] smallSig1(input logic [LANE_W-1:0] x);
    return {x[16:0], x[31:17]} ^ {x[18:0], x[31:19]} ^ (x >> 10);
  endfunction
endpackage

// File: rtl/msgsched_ctrl.sv
module msgsched_ctrl
  import msgsched_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          opSel,
  output schedStrobes_t strobes,
  output logic          outValid
);
  always_comb begin
    strobes.load     = inValid;
    strobes.finishOp = opSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/msgsched_dpath.sv
module msgsched_dpath
  import msgsched_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int NL = LANES
) (
  input  logic          clk,
  input  logic          rstN,
  input  schedStrobes_t strobes,
  input  logic [LW*NL-1:0] dstVec,
  input  logic [LW*NL-1:0] srcA,
  input  logic [LW*NL-1:0] srcB,
  output logic [LW*NL-1:0] result
);
  localparam int HALF = NL / 2;

  logic [LW-1:0] dL [NL];
  logic [LW-1:0] aL [NL];
  logic [LW-1:0] bL [NL];
  logic [LW-1:0] partL [NL];
  logic [LW-1:0] finL  [NL];
  logic [LW*NL-1:0] nextVec;

  for (genvar i = 0; i < NL; i++) begin : g_split
    assign dL[i] = dstVec[i*LW +: LW];
    assign aL[i] = srcA[i*LW +: LW];
    assign bL[i] = srcB[i*LW +: LW];
  end

  // Partial update: each lane mixes in sigma-0 of the next-older word.
  for (genvar i = 0; i < NL; i++) begin : g_part
    if (i < NL - 1) begin : g_inner
      assign partL[i] = smallSig0(dL[i+1]) + dL[i];
    end else begin : g_edge
      assign partL[i] = smallSig0(aL[0]) + dL[i];
    end
  end

  // Completing update: lower half from srcB, upper half chained on lower half.
  for (genvar i = 0; i < NL; i++) begin : g_fin
    if (i < HALF) begin : g_low
      assign finL[i] = smallSig1(bL[i+HALF]) + dL[i] + aL[i+1];
    end else if (i < NL - 1) begin : g_highMid
      assign finL[i] = smallSig1(finL[i-HALF]) + dL[i] + aL[i+1];
    end else begin : g_highTop
      assign finL[i] = smallSig1(finL[i-HALF]) + dL[i] + bL[0];
    end
  end

  for (genvar i = 0; i < NL; i++) begin : g_mux
    assign nextVec[i*LW +: LW] = strobes.finishOp ? finL[i] : partL[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN)             result <= '0;
    else if (strobes.load) result <= nextVec;
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(result));
endmodule

// File: rtl/msg_sched_unit.sv
module msg_sched_unit
  import msgsched_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             opSel,
  input  logic [VEC_W-1:0] dstVec,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  output logic             outValid,
  output logic [VEC_W-1:0] result
);
  schedStrobes_t strobes;

  msgsched_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .strobes(strobes), .outValid(outValid)
  );

  msgsched_dpath #(.LW(LANE_W), .NL(LANES)) i_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .dstVec(dstVec), .srcA(srcA), .srcB(srcB), .result(result)
  );

  // R4
  part_top_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !opSel) |=> result[127:96] ==
      smallSig0($past(srcA[31:0])) + $past(dstVec[127:96]));
  // R6
  fin_chain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel) |=> result[95:64] ==
      smallSig1(result[31:0]) + $past(dstVec[95:64]) + $past(srcA[127:96]));
endmodule

// File: tb/test_msg_sched_unit.sv
module test_msg_sched_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic opSel = 1'b0;
  logic [127:0] dstVec = '0, srcA = '0, srcB = '0;
  logic outValid;
  logic [127:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic         pendValid = 0;
  logic         pendOp = 0;
  logic [127:0] pendExp = '0;
  logic [127:0] lastExp = '0;

  always #2.5 clk = ~clk;

  msg_sched_unit i_msg_sched_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .dstVec(dstVec), .srcA(srcA), .srcB(srcB),
    .outValid(outValid), .result(result)
  );

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction
  function automatic logic [31:0] s0(input logic [31:0] x);
    return rr(x, 7) ^ rr(x, 18) ^ (x >> 3);
  endfunction
  function automatic logic [31:0] s1(input logic [31:0] x);
    return rr(x, 17) ^ rr(x, 19) ^ (x >> 10);
  endfunction
  function automatic logic [31:0] ln(input logic [127:0] v, input int k);
    return v[k*32 +: 32];
  endfunction

  function automatic logic [127:0] model(input logic op, input logic [127:0] d,
                                         input logic [127:0] a, input logic [127:0] b);
    logic [31:0] r0, r1, r2, r3;
    if (!op) begin
      r0 = s0(ln(d,1)) + ln(d,0);
      r1 = s0(ln(d,2)) + ln(d,1);
      r2 = s0(ln(d,3)) + ln(d,2);
      r3 = s0(ln(a,0)) + ln(d,3);
    end else begin
      r0 = s1(ln(b,2)) + ln(d,0) + ln(a,1);
      r1 = s1(ln(b,3)) + ln(d,1) + ln(a,2);
      r2 = s1(r0) + ln(d,2) + ln(a,3);
      r3 = s1(r1) + ln(d,3) + ln(b,0);
    end
    return {r3, r2, r1, r0};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: check what the previous cycle produced, then drive new inputs.
  task automatic cyc(input logic v, input logic op, input logic [127:0] d,
                     input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    chk("R2 outValid", {127'd0, outValid}, {127'd0, pendValid});
    if (pendValid) begin
      if (!pendOp) begin
        chk("R3 lanes0-2", result[95:0], pendExp[95:0]);
        chk("R4 lane3", result[127:96], pendExp[127:96]);
      end else begin
        chk("R5 lanes0-1", result[63:0], pendExp[63:0]);
        chk("R6 lanes2-3", result[127:64], pendExp[127:64]);
      end
      lastExp = pendExp;
    end else begin
      chk("R7 hold", result, lastExp);
    end
    inValid = v; opSel = op; dstVec = d; srcA = a; srcB = b;
    pendValid = v; pendOp = op;
    if (v) pendExp = model(op, d, a, b);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] d, a, b, first;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 outValid", {127'd0, outValid}, 128'd0);
    chk("R1 result", result, 128'd0);

    // R9 lane placement: single nonzero lane values
    cyc(1, 0, 128'h00000000_00000000_00000001_00000000, 128'h0, 128'h0);
    cyc(0, 0, 0, 0, 0);
    // expected lane0 = s0(1) = 0x02004000, lane1 = 1
    chk("R9 lane order", lastExp, 128'h00000000_00000000_00000001_02004000);
    chk("R9 lane order result", result, 128'h00000000_00000000_00000001_02004000);

    // R9 wrap: all ones in both ops
    cyc(1, 0, '1, '1, '1);
    cyc(1, 1, '1, '1, '1);
    cyc(0, 0, 0, 0, 0);
    chk("R9 wrap", result, model(1, '1, '1, '1));

    // R8: partial op ignores srcB and srcA upper lanes
    d = rnd128(); a = rnd128();
    cyc(1, 0, d, a, rnd128());
    cyc(0, 0, 0, 0, 0);
    first = result;
    cyc(1, 0, d, {~a[127:32], a[31:0]}, ~srcB);
    cyc(0, 0, 0, 0, 0);
    chk("R8 ignored operands", result, first);

    // Back-to-back sweeps with alternating and random op, with gaps (R3-R7)
    for (int n = 0; n < 3000; n++) begin
      logic v;
      logic op;
      v = ($urandom % 4) != 0;
      op = (n % 3 == 0) ? n[0] : $urandom % 2;
      d = rnd128(); a = rnd128(); b = rnd128();
      cyc(v, op, d, a, b);
    end
    // strict alternation
    for (int n = 0; n < 200; n++) begin
      cyc(1, n[0], rnd128(), rnd128(), rnd128());
    end
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule